// File: doc/BRIEF.md
# Isolated Cache Behaviour Estimator

This block sits beside a shared cache used by two applications and estimates how each application would behave if it had the cache to itself. A small, fixed group of sets is set aside for each application. In a "full" monitor set only the owning application may allocate, and every other application bypasses the set. In a "half" monitor set the owner may allocate only into the lower half of the ways, while the other applications use the set as usual. Every other set is a plain follower set and is neither restricted nor counted.

For each lookup, the cache presents the requesting application, the low bits of the set index and the hit or miss result. In the same cycle the block returns whether a fill is allowed and which ways a fill may use. An access by the owner in one of its own monitor sets updates an access counter, and a miss counter on a miss. Each application has a separate pair of counters for full sets and for half sets. When a count would pass its maximum, all four counters of that application are halved together, so their ratios survive. Software reads any counter through a small combinational read port.

Top module: `iso_cache_estimator`

## Requirements
- R1: The monitor type of a set comes from the low 5 index bits (`acc_set_lsb`). The value 2*a marks a full monitor set of application a, and 2*a+1 marks a half monitor set of application a: 0 is app 0 full, 1 is app 0 half, 2 is app 1 full and 3 is app 1 half. Every other value marks a follower set. This gives each application 32 sets of each type in a 1024-set cache.
- R2: When the owner accesses its own full monitor set, `fill_ok` is 1 and `way_mask` is all ones (8'hFF).
- R3: When any other application accesses a full monitor set, `fill_ok` is 0, `way_mask` is 0 and no counter changes.
- R4: When the owner accesses its own half monitor set, `fill_ok` is 1 and `way_mask` covers only the lower half of the ways (8'h0F).
- R5: When any other application accesses a half monitor set, `fill_ok` is 1, `way_mask` is 8'hFF and no counter changes.
- R6: An access to a follower set gives `fill_ok` = 1 and `way_mask` = 8'hFF, and no counter changes.
- R7: An owner access to its own monitor set raises that application's access counter for that set type by one on the next clock edge. If `acc_hit` is 0, the matching miss counter also rises by one.
- R8: If an increment would take any counter of an application past 2^15-1, all four counters of that application first become floor(value/2), and then this access's increments are added. The counters of the other application do not change.
- R9: After reset all counters read 0.
- R10: `rd_data` combinationally shows the counter picked by `rd_app` and `rd_sel`, where 0 is full-set accesses, 1 is full-set misses, 2 is half-set accesses and 3 is half-set misses.
- R11: While `acc_valid` is 0, `fill_ok` is 0, `way_mask` is 0 and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A lookup is presented this cycle |
| acc_app | input | 1 | Requesting application |
| acc_set_lsb | input | 5 | Low bits of the accessed set index |
| acc_hit | input | 1 | Lookup result: 1 for a hit, 0 for a miss |
| fill_ok | output | 1 | A fill is permitted for this access |
| way_mask | output | 8 | Ways a fill may use |
| rd_app | input | 1 | Application whose counter is read |
| rd_sel | input | 2 | Counter selector |
| rd_data | output | 15 | Selected counter value |

## Verification
The hardest state to reach is the saturation halving. It appears only after an application's counter has been driven to 32767 through its own monitor sets, at one access per cycle. The stimulus therefore streams about 32,000 owner accesses into a single full set, with a miss mixed in every few accesses. It stops exactly when the bench's model counter reaches the top, and then sends one more access that is a miss. The read port then shows all four counters of that application halved, with the new increments added. The other application's counters, set up earlier, must read back unchanged.

// File: rtl/iso_pkg.sv
package iso_pkg;
    typedef enum logic [1:0] {
        MON_NONE = 2'd0,
        MON_FULL = 2'd1,
        MON_HALF = 2'd2
    } mon_kind_e;
endpackage

// File: rtl/iso_set_decode.sv
module iso_set_decode
    import iso_pkg::*;
#(
    parameter int RES_W    = 5,
    parameter int NUM_APPS = 2,
    parameter int APP_W    = 1
) (
    input  logic [RES_W-1:0] res,
    output mon_kind_e        kind,
    output logic [APP_W-1:0] owner
);
    // Two residues per application: even value = full set, odd value = half set.
    always_comb begin
        kind  = MON_NONE;
        owner = '0;
        for (int a = 0; a < NUM_APPS; a++) begin
            if (res == RES_W'(2 * a)) begin
                kind  = MON_FULL;
                owner = APP_W'(a);
            end else if (res == RES_W'(2 * a + 1)) begin
                kind  = MON_HALF;
                owner = APP_W'(a);
            end
        end
    end
endmodule

// File: rtl/iso_way_policy.sv
module iso_way_policy
    import iso_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int APP_W = 1
) (
    input  logic             acc_valid,
    input  logic [APP_W-1:0] acc_app,
    input  mon_kind_e        kind,
    input  logic [APP_W-1:0] owner,
    output logic             fill_ok,
    output logic [WAYS-1:0]  way_mask,
    output logic             cnt_en
);
    localparam int              HALF_WAYS = WAYS / 2;
    localparam logic [WAYS-1:0] ALL_WAYS  = '1;
    localparam logic [WAYS-1:0] LOW_WAYS  = ALL_WAYS >> (WAYS - HALF_WAYS);

    logic is_owner;

    always_comb begin
        is_owner = (acc_app == owner);
        fill_ok  = 1'b0;
        way_mask = '0;
        cnt_en   = 1'b0;
        if (acc_valid) begin
            case (kind)
                MON_FULL: begin
                    if (is_owner) begin
                        fill_ok  = 1'b1;
                        way_mask = ALL_WAYS;
                        cnt_en   = 1'b1;
                    end
                end
                MON_HALF: begin
                    fill_ok  = 1'b1;
                    way_mask = is_owner ? LOW_WAYS : ALL_WAYS;
                    cnt_en   = is_owner;
                end
                default: begin
                    fill_ok  = 1'b1;
                    way_mask = ALL_WAYS;
                end
            endcase
        end
    end
endmodule

// File: rtl/iso_app_counters.sv
module iso_app_counters #(
    parameter int CNT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_en,
    input  logic               is_half,
    input  logic               miss,
    input  logic [1:0]         rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    output logic [4*CNT_W-1:0] cnt_vec
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] f_acc;
        logic [CNT_W-1:0] f_mis;
        logic [CNT_W-1:0] h_acc;
        logic [CNT_W-1:0] h_mis;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  inc_fa, inc_fm, inc_ha, inc_hm, sat;

    always_comb begin
        inc_fa = inc_en && !is_half;
        inc_fm = inc_fa && miss;
        inc_ha = inc_en && is_half;
        inc_hm = inc_ha && miss;
        sat    = (inc_fa && bank_q.f_acc == CNT_MAX) || (inc_fm && bank_q.f_mis == CNT_MAX) ||
                 (inc_ha && bank_q.h_acc == CNT_MAX) || (inc_hm && bank_q.h_mis == CNT_MAX);
        bank_d = bank_q;
        if (sat) begin
            bank_d.f_acc = bank_q.f_acc >> 1;
            bank_d.f_mis = bank_q.f_mis >> 1;
            bank_d.h_acc = bank_q.h_acc >> 1;
            bank_d.h_mis = bank_q.h_mis >> 1;
        end
        bank_d.f_acc = bank_d.f_acc + CNT_W'(inc_fa);
        bank_d.f_mis = bank_d.f_mis + CNT_W'(inc_fm);
        bank_d.h_acc = bank_d.h_acc + CNT_W'(inc_ha);
        bank_d.h_mis = bank_d.h_mis + CNT_W'(inc_hm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = bank_q.f_acc;
            2'd1:    rd_data = bank_q.f_mis;
            2'd2:    rd_data = bank_q.h_acc;
            default: rd_data = bank_q.h_mis;
        endcase
        cnt_vec = bank_q;
    end
endmodule

// File: rtl/iso_cache_estimator.sv
module iso_cache_estimator
    import iso_pkg::*;
#(
    parameter  int SETS     = 1024,
    parameter  int MON_SETS = 32,
    parameter  int WAYS     = 8,
    parameter  int NUM_APPS = 2,
    parameter  int CNT_W    = 15,
    localparam int RES_W    = $clog2(SETS / MON_SETS),
    localparam int APP_W    = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [APP_W-1:0] acc_app,
    input  logic [RES_W-1:0] acc_set_lsb,
    input  logic             acc_hit,
    output logic             fill_ok,
    output logic [WAYS-1:0]  way_mask,
    input  logic [APP_W-1:0] rd_app,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    mon_kind_e                       kind;
    logic [APP_W-1:0]                owner;
    logic                            cnt_en;
    logic [CNT_W-1:0]                bank_rd [NUM_APPS];
    logic [NUM_APPS*4*CNT_W-1:0]     cnt_flat;

    iso_set_decode #(.RES_W(RES_W), .NUM_APPS(NUM_APPS), .APP_W(APP_W)) u_decode (
        .res   (acc_set_lsb),
        .kind  (kind),
        .owner (owner)
    );

    iso_way_policy #(.WAYS(WAYS), .APP_W(APP_W)) u_policy (
        .acc_valid (acc_valid),
        .acc_app   (acc_app),
        .kind      (kind),
        .owner     (owner),
        .fill_ok   (fill_ok),
        .way_mask  (way_mask),
        .cnt_en    (cnt_en)
    );

    for (genvar a = 0; a < NUM_APPS; a++) begin : g_bank
        iso_app_counters #(.CNT_W(CNT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_en  (cnt_en && (owner == APP_W'(a))),
            .is_half (kind == MON_HALF),
            .miss    (!acc_hit),
            .rd_sel  (rd_sel),
            .rd_data (bank_rd[a]),
            .cnt_vec (cnt_flat[a*4*CNT_W +: 4*CNT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int a = 0; a < NUM_APPS; a++) begin
            if (rd_app == APP_W'(a)) rd_data = bank_rd[a];
        end
    end
endmodule

// File: rtl/iso_estimator_chk.sv
module iso_estimator_chk #(
    parameter int WAYS     = 8,
    parameter int NUM_APPS = 2,
    parameter int CNT_W    = 15,
    parameter int RES_W    = 5,
    parameter int APP_W    = 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        acc_valid,
    input logic [APP_W-1:0]            acc_app,
    input logic [RES_W-1:0]            acc_set_lsb,
    input logic                        fill_ok,
    input logic [WAYS-1:0]             way_mask,
    input logic [NUM_APPS*4*CNT_W-1:0] cnt_flat
);
    localparam logic [WAYS-1:0] LOW = {{(WAYS - WAYS/2){1'b0}}, {(WAYS/2){1'b1}}};

    logic             is_mon, is_half, is_own;
    logic [APP_W-1:0] set_owner;

    always_comb begin
        is_mon    = 32'(acc_set_lsb) < 2 * NUM_APPS;
        is_half   = acc_set_lsb[0];
        set_owner = APP_W'(acc_set_lsb >> 1);
        is_own    = (acc_app == set_owner);
    end

    AST_FULL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && is_mon && !is_half && !is_own |-> !fill_ok && way_mask == '0); // R3

    AST_FULL_BYPASS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && is_mon && !is_own |=> $stable(cnt_flat)); // R5

    AST_HALF_OWNER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && is_mon && is_half && is_own |-> fill_ok && way_mask == LOW); // R4

    AST_FOLLOWER_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !is_mon |=> $stable(cnt_flat)); // R6

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(cnt_flat)); // R11

    AST_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !fill_ok && way_mask == '0); // R11

    for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
        localparam int B = a * 4 * CNT_W;
        AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[B+2*CNT_W +: CNT_W] <= cnt_flat[B+3*CNT_W +: CNT_W] &&
            cnt_flat[B +: CNT_W] <= cnt_flat[B+CNT_W +: CNT_W]); // R7
    end
endmodule

bind iso_cache_estimator iso_estimator_chk #(
    .WAYS(WAYS), .NUM_APPS(NUM_APPS), .CNT_W(CNT_W), .RES_W(RES_W), .APP_W(APP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_app     (acc_app),
    .acc_set_lsb (acc_set_lsb),
    .fill_ok     (fill_ok),
    .way_mask    (way_mask),
    .cnt_flat    (cnt_flat)
);

// File: tb/tb_iso_cache_estimator.sv
`timescale 1ns/1ps
module tb_iso_cache_estimator;
    localparam int MAXC = 32767;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [0:0]  acc_app = '0;
    logic [4:0]  acc_set_lsb = '0;
    logic        acc_hit = 1'b0;
    logic        fill_ok;
    logic [7:0]  way_mask;
    logic [0:0]  rd_app = '0;
    logic [1:0]  rd_sel = '0;
    logic [14:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int mdl [2][4];

    typedef struct {
        logic       fill;
        logic [7:0] mask;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    iso_cache_estimator dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_app(acc_app),
        .acc_set_lsb(acc_set_lsb), .acc_hit(acc_hit), .fill_ok(fill_ok),
        .way_mask(way_mask), .rd_app(rd_app), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference counter model taken from R7 and R8.
    task automatic model_count(int app, bit half, bit miss);
        int b;
        bit sat;
        b = half ? 2 : 0;
        sat = (mdl[app][b] == MAXC) || (miss && mdl[app][b+1] == MAXC);
        if (sat) for (int s = 0; s < 4; s++) mdl[app][s] = mdl[app][s] >> 1;
        mdl[app][b]++;
        if (miss) mdl[app][b+1]++;
    endtask

    // Driver: present one access and queue the expected fill decision (R1..R6).
    task automatic access(int app, int set, bit hit, string tag);
        exp_t e;
        int res;
        res = set % 32;
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_app = app[0:0]; acc_set_lsb = res[4:0]; acc_hit = hit;
        e.tag = tag;
        if (res < 4) begin
            if (res[0] == 1'b0) begin
                e.fill = (app == res / 2);
                e.mask = (app == res / 2) ? 8'hFF : 8'h00;
            end else begin
                e.fill = 1'b1;
                e.mask = (app == res / 2) ? 8'h0F : 8'hFF;
            end
            if (app == res / 2) model_count(app, res[0], !hit);
        end else begin
            e.fill = 1'b1;
            e.mask = 8'hFF;
        end
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 4; s++) begin
                rd_app = a[0:0]; rd_sel = s[1:0]; #1;
                chk($sformatf("%s app%0d sel%0d", tag, a, s), int'(rd_data), mdl[a][s]);
            end
        end
    endtask

    // Monitor: compare each presented access against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (acc_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected access", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " fill_ok"}, int'(fill_ok), int'(e.fill));
                    chk({e.tag, " way_mask"}, int'(way_mask), int'(e.mask));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        for (int a = 0; a < 2; a++) for (int s = 0; s < 4; s++) mdl[a][s] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        read_all("R9 reset");
        chk("R11 idle fill_ok", int'(fill_ok), 0);
        chk("R11 idle way_mask", int'(way_mask), 0);

        access(0, 0, 1'b1, "R2 own full hit");
        access(0, 32, 1'b0, "R2 own full miss");
        access(0, 64, 1'b0, "R7 own full miss");
        access(1, 32, 1'b0, "R3 bypass full");
        access(1, 0, 1'b1, "R3 bypass full hit");
        access(0, 1, 1'b0, "R4 own half miss");
        access(0, 33, 1'b1, "R4 own half hit");
        access(1, 1, 1'b0, "R5 other half");
        access(1, 2, 1'b0, "R2 app1 own full");
        access(1, 3, 1'b1, "R4 app1 own half");
        access(1, 35, 1'b0, "R4 app1 own half miss");
        access(0, 2, 1'b0, "R3 app0 bypass app1 full");
        access(0, 3, 1'b0, "R5 app0 other half");
        access(0, 4, 1'b0, "R6 follower");
        access(1, 31, 1'b0, "R6 follower top");
        access(0, 100, 1'b0, "R1 residue 4 follower");
        access(1, 5, 1'b1, "R6 follower 5");
        idle();
        read_all("R7 R10 counters");

        // Drive app 0 full access counter to the top, then one more miss (R8).
        n = 0;
        while (mdl[0][0] < MAXC) begin
            access(0, 96, (n % 7) != 0, "R8 fill up");
            n++;
        end
        idle();
        rd_app = 1'b0; rd_sel = 2'd0; #1;
        chk("R8 at top", int'(rd_data), MAXC);
        access(0, 0, 1'b0, "R8 overflow access");
        idle();
        rd_app = 1'b0; rd_sel = 2'd0; #1;
        chk("R8 halved access", int'(rd_data), 16384);
        read_all("R8 halved all");
        access(0, 1, 1'b0, "R7 half after halving");
        idle();
        read_all("R7 after halving");

        while (exp_q.size() != 0) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule